// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block is the hardware loop that turns one vector instruction into a run of per-element issue slots. A start command captures the vector length, the first element index to execute, a predication code and the three predicate words. It also captures, for each of the two operands, a base register number and a flag saying whether that operand is a vector or a scalar. From the next cycle on, the sequencer visits one element index per cycle. For each index it presents the source and destination register numbers, together with separate source-enable and destination-enable strobes. A scalar operand keeps its base register number. A vector operand's number moves forward with the element index.

The predication code is read in one of two ways. In single mode it picks one predicate word and a polarity, and the result gates source and destination together. In twin mode the source and the destination are gated independently. An element whose enables are both low is skipped: no strobe is raised, but the index still advances. When a predicated operand is a scalar, the loop ends on the first element for which that operand's enable is high.

A downstream trap on an issued element stops the loop and leaves the failing index on the resume output, so that software can restart from that index. Normal completion pulses done and clears the resume index.

Top module: `vec_elem_seq`

## Requirements
- R1: While reset is asserted and after it is released, done, src_en and dst_en are 0 and resume_idx is 0; a reset also clears a resume_idx left by an earlier trap.
- R2: With twin_mode=0, the 3-bit pred_code selects the predicate as follows. Codes 0 and 1 leave the element unpredicated. Codes 2 and 3 use pred_x9, codes 4 and 5 use pred_x10, and codes 6 and 7 use pred_x11, taking bit i for element i. An even code enables element i when that bit is 0 and an odd code enables it when the bit is 1. src_en and dst_en both follow the result.
- R3: With twin_mode=1, pred_code bit 0 gates the source with bit i of pred_x9 and bit 1 gates the destination with bit i of pred_x10. Bit 2 inverts the polarity: a gated enable is high when the bit is 1 if code bit 2 is 0, and when it is 0 if code bit 2 is 1. An ungated side is always enabled, so codes 0 and 4 are unpredicated.
- R4: An operand whose vec flag is 0 presents its captured base register number unchanged for every element.
- R5: An operand whose vec flag is 1 presents base plus element index, modulo 2^REG_W.
- R6: The loop starts at vstart_in, one element per cycle, with elem_idx rising by one each cycle. A disabled element raises no strobe but still uses its cycle. No strobe is raised outside a run.
- R7: If an operand is scalar and predicated, the element on which that operand's enable is first high is issued and the loop then ends with done.
- R8: After the last element (index vl-1) the loop ends; done is high for exactly the one following cycle and resume_idx becomes 0.
- R9: trap_in high during a cycle in which an element is issued ends the loop without done and sets resume_idx to that element's index.
- R10: A start with vl_in = 0 or vstart_in >= vl_in issues no element and raises done in the cycle after the start edge. vl_in may be as large as XLEN.
- R11: start while a run is in progress is ignored; the run continues with its captured settings.
- R12: trap_in during a cycle with no issued element has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a run when idle |
| vl_in | input | IDX_W | Vector length, 0..XLEN |
| vstart_in | input | IDX_W | First element index to execute |
| twin_mode | input | 1 | 0: single predication code, 1: twin code |
| pred_code | input | 3 | Predication code |
| pred_x9 | input | XLEN | First predicate word |
| pred_x10 | input | XLEN | Second predicate word |
| pred_x11 | input | XLEN | Third predicate word |
| src_base | input | REG_W | Source base register number |
| dst_base | input | REG_W | Destination base register number |
| src_vec | input | 1 | Source is a vector (1) or a scalar (0) |
| dst_vec | input | 1 | Destination is a vector (1) or a scalar (0) |
| trap_in | input | 1 | Trap on the element issued this cycle |
| src_en | output | 1 | Source strobe for the current element |
| dst_en | output | 1 | Destination strobe for the current element |
| elem_idx | output | IDX_W | Current element index |
| src_reg | output | REG_W | Source register number for the current element |
| dst_reg | output | REG_W | Destination register number for the current element |
| done | output | 1 | One-cycle pulse on completion |
| resume_idx | output | IDX_W | Index to resume from after a trap, 0 otherwise |

## Verification
The first element's strobes, index and register numbers are valid in the cycle after the start edge. Each later element follows one cycle after the one before it. done and the cleared resume_idx are valid in the cycle after the edge that consumes the last element. A trap's resume index is valid in the cycle after the edge that consumes trap_in. The bench drives on the falling edge and samples on the next falling edge after each rising edge, so every check sits exactly one register stage after the stimulus that caused it. A per-element reference walk gives the expected strobes and register numbers, and a hand count of issued elements per vector cross-checks it.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  // Per-operand predicate outcome for the current element
  typedef struct packed {
    logic enable;   // operand takes part in this element
    logic gated;    // a predicate word applies to this operand
  } opnd_gate_t;

endpackage

// File: rtl/vseq_pred_decode.sv
module vseq_pred_decode
  import vseq_pkg::*;
(
  input  logic       twin_mode,
  input  logic [2:0] code,
  input  logic       bit_x9,
  input  logic       bit_x10,
  input  logic       bit_x11,
  output opnd_gate_t src_gate,
  output opnd_gate_t dst_gate
);

  logic sel_bit;
  logic single_gated;
  logic single_en;

  // Single mode: upper two code bits pick a word, bit 0 picks polarity
  always_comb begin
    unique case (code[2:1])
      2'b01:   sel_bit = bit_x9;
      2'b10:   sel_bit = bit_x10;
      2'b11:   sel_bit = bit_x11;
      default: sel_bit = 1'b0;
    endcase
    single_gated = (code[2:1] != 2'b00);
    single_en    = single_gated ? (code[0] ? sel_bit : ~sel_bit) : 1'b1;
  end

  // Twin mode: bit 0 gates source, bit 1 gates destination, bit 2 inverts
  always_comb begin
    if (twin_mode) begin
      src_gate.gated  = code[0];
      src_gate.enable = code[0] ? (bit_x9 ^ code[2]) : 1'b1;
      dst_gate.gated  = code[1];
      dst_gate.enable = code[1] ? (bit_x10 ^ code[2]) : 1'b1;
    end else begin
      src_gate.gated  = single_gated;
      src_gate.enable = single_en;
      dst_gate.gated  = single_gated;
      dst_gate.enable = single_en;
    end
  end

endmodule

// File: rtl/vseq_opnd_map.sv
module vseq_opnd_map #(
  parameter int REG_W = 7,
  parameter int IDX_W = 7
) (
  input  logic [REG_W-1:0] base,
  input  logic             is_vec,
  input  logic [IDX_W-1:0] idx,
  output logic [REG_W-1:0] reg_num
);

  logic [REG_W-1:0] step;

  always_comb begin
    step    = REG_W'(idx);
    reg_num = is_vec ? (base + step) : base;
  end

endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] vl_in,
  input  logic [IDX_W-1:0] vstart_in,
  input  logic             issue,
  input  logic             stop_here,
  input  logic             trap_in,
  output logic             run_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             done,
  output logic [IDX_W-1:0] resume_idx,
  output logic             cfg_load
);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_d;
  logic [IDX_W-1:0] vl_q, vl_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] resume_q, resume_d;
  logic             empty;
  logic             last;
  logic [IDX_W:0]   idx_next;

  always_comb begin
    empty    = (vl_in == '0) || (vstart_in >= vl_in);
    idx_next = {1'b0, idx_q} + 1'b1;
    last     = (idx_next >= {1'b0, vl_q});
    cfg_load = (state_q == ST_IDLE) && start;
  end

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    vl_d     = vl_q;
    done_d   = 1'b0;
    resume_d = resume_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (empty) begin
            done_d   = 1'b1;
            resume_d = '0;
          end else begin
            state_d = ST_RUN;
            idx_d   = vstart_in;
            vl_d    = vl_in;
          end
        end
      end
      ST_RUN: begin
        if (trap_in && issue) begin
          state_d  = ST_IDLE;
          resume_d = idx_q;
        end else if (stop_here || last) begin
          state_d  = ST_IDLE;
          done_d   = 1'b1;
          resume_d = '0;
        end else begin
          idx_d = idx_next[IDX_W-1:0];
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      vl_q     <= '0;
      done_q   <= 1'b0;
      resume_q <= '0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      vl_q     <= vl_d;
      done_q   <= done_d;
      resume_q <= resume_d;
    end
  end

  assign run_q      = (state_q == ST_RUN);
  assign done       = done_q;
  assign resume_idx = resume_q;

endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
  import vseq_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int REG_W = 7,
  parameter int IDX_W = $clog2(XLEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] vl_in,
  input  logic [IDX_W-1:0] vstart_in,
  input  logic             twin_mode,
  input  logic [2:0]       pred_code,
  input  logic [XLEN-1:0]  pred_x9,
  input  logic [XLEN-1:0]  pred_x10,
  input  logic [XLEN-1:0]  pred_x11,
  input  logic [REG_W-1:0] src_base,
  input  logic [REG_W-1:0] dst_base,
  input  logic             src_vec,
  input  logic             dst_vec,
  input  logic             trap_in,
  output logic             src_en,
  output logic             dst_en,
  output logic [IDX_W-1:0] elem_idx,
  output logic [REG_W-1:0] src_reg,
  output logic [REG_W-1:0] dst_reg,
  output logic             done,
  output logic [IDX_W-1:0] resume_idx
);

  localparam int NUM_OPND = 2;
  localparam int BIT_W    = (XLEN > 1) ? $clog2(XLEN) : 1;
  localparam logic [IDX_W:0] XLEN_V = (IDX_W + 1)'(XLEN);

  // Captured configuration
  logic             twin_q;
  logic [2:0]       code_q;
  logic [XLEN-1:0]  p9_q, p10_q, p11_q;
  logic [REG_W-1:0] base_q [NUM_OPND];
  logic             vec_q  [NUM_OPND];
  logic             src_vec_q, dst_vec_q;

  logic             run_q;
  logic [IDX_W-1:0] idx_q;
  logic             cfg_load;
  logic             in_range;
  logic [BIT_W-1:0] bit_sel;
  logic             b9, b10, b11;
  opnd_gate_t       src_gate, dst_gate;
  logic             issue;
  logic             stop_here;
  logic [REG_W-1:0] reg_out [NUM_OPND];

  // Configuration capture with explicit load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twin_q    <= 1'b0;
      code_q    <= '0;
      p9_q      <= '0;
      p10_q     <= '0;
      p11_q     <= '0;
      base_q[0] <= '0;
      base_q[1] <= '0;
      vec_q[0]  <= 1'b0;
      vec_q[1]  <= 1'b0;
    end else if (cfg_load) begin
      twin_q    <= twin_mode;
      code_q    <= pred_code;
      p9_q      <= pred_x9;
      p10_q     <= pred_x10;
      p11_q     <= pred_x11;
      base_q[0] <= src_base;
      base_q[1] <= dst_base;
      vec_q[0]  <= src_vec;
      vec_q[1]  <= dst_vec;
    end
  end

  assign src_vec_q = vec_q[0];
  assign dst_vec_q = vec_q[1];

  // Predicate bit of the current element
  always_comb begin
    in_range = ({1'b0, idx_q} < XLEN_V);
    bit_sel  = idx_q[BIT_W-1:0];
    b9       = in_range & p9_q[bit_sel];
    b10      = in_range & p10_q[bit_sel];
    b11      = in_range & p11_q[bit_sel];
  end

  vseq_pred_decode u_pred (
    .twin_mode (twin_q),
    .code      (code_q),
    .bit_x9    (b9),
    .bit_x10   (b10),
    .bit_x11   (b11),
    .src_gate  (src_gate),
    .dst_gate  (dst_gate)
  );

  always_comb begin
    src_en    = run_q & src_gate.enable;
    dst_en    = run_q & dst_gate.enable;
    issue     = src_en | dst_en;
    stop_here = (src_en & src_gate.gated & ~src_vec_q)
              | (dst_en & dst_gate.gated & ~dst_vec_q);
  end

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    vseq_opnd_map #(
      .REG_W (REG_W),
      .IDX_W (IDX_W)
    ) u_map (
      .base    (base_q[g]),
      .is_vec  (vec_q[g]),
      .idx     (idx_q),
      .reg_num (reg_out[g])
    );
  end

  assign src_reg  = reg_out[0];
  assign dst_reg  = reg_out[1];
  assign elem_idx = idx_q;

  vseq_ctrl #(
    .IDX_W (IDX_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .vl_in      (vl_in),
    .vstart_in  (vstart_in),
    .issue      (issue),
    .stop_here  (stop_here),
    .trap_in    (trap_in),
    .run_q      (run_q),
    .idx_q      (idx_q),
    .done       (done),
    .resume_idx (resume_idx),
    .cfg_load   (cfg_load)
  );

endmodule

// File: rtl/vseq_chk.sv
module vseq_chk #(
  parameter int REG_W = 7,
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_q,
  input logic             src_vec_q,
  input logic             dst_vec_q,
  input logic             src_en,
  input logic             dst_en,
  input logic [IDX_W-1:0] elem_idx,
  input logic [REG_W-1:0] src_reg,
  input logic [REG_W-1:0] dst_reg,
  input logic             done,
  input logic             trap_in
);

  // No strobe outside a run
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!src_en && !dst_en));

  // Index steps by one each cycle within a run
  assert_idx_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> (elem_idx == IDX_W'($past(elem_idx) + 1'b1)));

  // Scalar operand register number holds
  assert_scalar_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && !src_vec_q) |-> $stable(src_reg));

  // Vector operand register number steps
  assert_vec_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && dst_vec_q) |-> (dst_reg == REG_W'($past(dst_reg) + 1'b1)));

  // done lasts one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // Trap on an issued element ends the run without done
  assert_trap_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && trap_in && (src_en || dst_en)) |=> (!done && !run_q));

endmodule

bind vec_elem_seq vseq_chk #(
  .REG_W (REG_W),
  .IDX_W (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_q     (run_q),
  .src_vec_q (src_vec_q),
  .dst_vec_q (dst_vec_q),
  .src_en    (src_en),
  .dst_en    (dst_en),
  .elem_idx  (elem_idx),
  .src_reg   (src_reg),
  .dst_reg   (dst_reg),
  .done      (done),
  .trap_in   (trap_in)
);

// File: tb/sim_vec_elem_seq.sv
module sim_vec_elem_seq;

  localparam int XLEN  = 64;
  localparam int REG_W = 7;
  localparam int IDX_W = 7;
  localparam int NVEC  = 14;

  typedef struct packed {
    logic        twin;
    logic [2:0]  code;
    logic [6:0]  vl;
    logic [6:0]  vs;
    logic [6:0]  sb;
    logic [6:0]  db;
    logic        sv;     // source is vector
    logic        dv;     // destination is vector
    logic [15:0] p9;
    logic [15:0] p10;
    logic [15:0] p11;
    logic [7:0]  trap_at; // 8'hFF: no trap
    logic [7:0]  cnt;     // expected issued elements
  } vec_t;

  function automatic vec_t mk(int twin, int code, int vl, int vs, int sb, int db,
                              int sv, int dv, int p9, int p10, int p11,
                              int trap_at, int cnt);
    vec_t v;
    v.twin = 1'(twin);  v.code = 3'(code);  v.vl = 7'(vl);   v.vs = 7'(vs);
    v.sb = 7'(sb);      v.db = 7'(db);      v.sv = 1'(sv);   v.dv = 1'(dv);
    v.p9 = 16'(p9);     v.p10 = 16'(p10);   v.p11 = 16'(p11);
    v.trap_at = 8'(trap_at); v.cnt = 8'(cnt);
    return v;
  endfunction

  localparam vec_t TBL [NVEC] = '{
    mk(0, 0,  5,  0,   3,  10, 1, 1, 'h0000, 'h0000, 'h0000, 255, 5), // R2 unpredicated
    mk(0, 3,  8,  0,   3,  10, 1, 1, 'h002D, 'h0000, 'h0000, 255, 4), // R2 x9 odd
    mk(0, 4,  8,  1,  20,  30, 1, 1, 'h0000, 'h002D, 'h0000, 255, 4), // R2 x10 even
    mk(0, 7, 10,  2,   5,  40, 0, 1, 'h0000, 'h0000, 'h00F0, 255, 1), // R7 x11 scalar stop
    mk(0, 1,  3,  0, 127,   0, 0, 0, 'h0000, 'h0000, 'h0000, 255, 3), // R2 reserved, R4
    mk(1, 1,  4,  0, 126,  50, 1, 1, 'h0006, 'h0000, 'h0000, 255, 4), // R3 src x9, R5 wrap
    mk(1, 2,  4,  0,   7,   9, 1, 0, 'h0000, 'h0009, 'h0000, 255, 1), // R7 dst scalar stop
    mk(1, 7,  6,  0,  60,  70, 1, 1, 'h000F, 'h0005, 'h0000, 255, 4), // R3 both inverted
    mk(1, 4,  2,  0,   1,   2, 1, 1, 'hFFFF, 'hFFFF, 'h0000, 255, 2), // R3 reserved 100
    mk(1, 5,  6,  0,  11,  12, 0, 1, 'h0003, 'h0000, 'h0000, 255, 3), // R7 src !x9 scalar
    mk(0, 2,  6,  1,  13,  14, 1, 1, 'h0000, 'h0000, 'h0000,   3, 3), // R9 trap
    mk(0, 0,  0,  0,   1,   1, 1, 1, 'h0000, 'h0000, 'h0000, 255, 0), // R10 vl=0
    mk(0, 0,  4,  4,   1,   1, 1, 1, 'h0000, 'h0000, 'h0000, 255, 0), // R10 vstart=vl
    mk(0, 0, 64, 60,  20, 120, 1, 1, 'h0000, 'h0000, 'h0000, 255, 4)  // R10 vl=XLEN, R5
  };

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [IDX_W-1:0] vl_in;
  logic [IDX_W-1:0] vstart_in;
  logic             twin_mode;
  logic [2:0]       pred_code;
  logic [XLEN-1:0]  pred_x9, pred_x10, pred_x11;
  logic [REG_W-1:0] src_base, dst_base;
  logic             src_vec, dst_vec;
  logic             trap_in;
  logic             src_en, dst_en;
  logic [IDX_W-1:0] elem_idx;
  logic [REG_W-1:0] src_reg, dst_reg;
  logic             done;
  logic [IDX_W-1:0] resume_idx;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  vec_elem_seq #(
    .XLEN  (XLEN),
    .REG_W (REG_W),
    .IDX_W (IDX_W)
  ) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .vl_in      (vl_in),
    .vstart_in  (vstart_in),
    .twin_mode  (twin_mode),
    .pred_code  (pred_code),
    .pred_x9    (pred_x9),
    .pred_x10   (pred_x10),
    .pred_x11   (pred_x11),
    .src_base   (src_base),
    .dst_base   (dst_base),
    .src_vec    (src_vec),
    .dst_vec    (dst_vec),
    .trap_in    (trap_in),
    .src_en     (src_en),
    .dst_en     (dst_en),
    .elem_idx   (elem_idx),
    .src_reg    (src_reg),
    .dst_reg    (dst_reg),
    .done       (done),
    .resume_idx (resume_idx)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference predicate outcome, written from R2 and R3
  task automatic ref_pred(input vec_t v, input int k,
                          output bit ps, output bit pd, output bit sg, output bit dg);
    bit b9, b10, b11, sel;
    b9  = (k < 16) ? v.p9[k]  : 1'b0;
    b10 = (k < 16) ? v.p10[k] : 1'b0;
    b11 = (k < 16) ? v.p11[k] : 1'b0;
    if (v.twin) begin
      sg = v.code[0];
      dg = v.code[1];
      ps = sg ? (v.code[2] ? !b9 : b9) : 1'b1;
      pd = dg ? (v.code[2] ? !b10 : b10) : 1'b1;
    end else begin
      case (v.code)
        3'd2, 3'd3: sel = b9;
        3'd4, 3'd5: sel = b10;
        default:    sel = b11;
      endcase
      if (v.code <= 3'd1) begin
        sg = 0; dg = 0; ps = 1; pd = 1;
      end else begin
        sg = 1; dg = 1;
        ps = v.code[0] ? sel : !sel;
        pd = ps;
      end
    end
  endtask

  task automatic run_case(input vec_t v, input bit trap_idle, input bit poke);
    int  k;
    int  issued;
    bit  ps, pd, sg, dg, tr, stp, lst;
    int  exp_s, exp_d;
    string ptag;
    ptag = v.twin ? "R3" : "R2";
    issued = 0;
    vl_in = v.vl; vstart_in = v.vs; twin_mode = v.twin; pred_code = v.code;
    pred_x9 = XLEN'(v.p9); pred_x10 = XLEN'(v.p10); pred_x11 = XLEN'(v.p11);
    src_base = v.sb; dst_base = v.db; src_vec = v.sv; dst_vec = v.dv;
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    if (v.vl == 0 || v.vs >= v.vl) begin
      chk(done == 1'b1, "R10 done after empty start", int'(done), 1);
      chk(!src_en && !dst_en, "R10 no strobe", int'(src_en | dst_en), 0);
      chk(resume_idx == 0, "R10 resume cleared", int'(resume_idx), 0);
      @(posedge clk); @(negedge clk);
      chk(done == 1'b0 && !src_en && !dst_en, "R10 stays quiet", int'(done | src_en | dst_en), 0);
    end else begin
      k = v.vs;
      forever begin
        ref_pred(v, k, ps, pd, sg, dg);
        chk(src_en == ps, {ptag, " src_en"}, int'(src_en), int'(ps));
        chk(dst_en == pd, {ptag, " dst_en"}, int'(dst_en), int'(pd));
        chk(done == 1'b0, "R6 no done mid-run", int'(done), 0);
        if (ps || pd) begin
          issued++;
          exp_s = v.sv ? int'(7'(v.sb + k)) : int'(v.sb);
          exp_d = v.dv ? int'(7'(v.db + k)) : int'(v.db);
          chk(int'(elem_idx) == k, "R6 elem_idx", int'(elem_idx), k);
          chk(int'(src_reg) == exp_s, v.sv ? "R5 src_reg" : "R4 src_reg", int'(src_reg), exp_s);
          chk(int'(dst_reg) == exp_d, v.dv ? "R5 dst_reg" : "R4 dst_reg", int'(dst_reg), exp_d);
        end
        tr  = (ps || pd) && (k == int'(v.trap_at));
        trap_in = tr || (trap_idle && !(ps || pd));
        if (poke && k == int'(v.vs) + 1) begin
          start = 1'b1; vl_in = 7'd2; vstart_in = 7'd0;   // R11 ignored
        end
        stp = (sg && !v.sv && ps) || (dg && !v.dv && pd);
        lst = (k + 1 >= int'(v.vl));
        @(posedge clk); @(negedge clk);
        trap_in = 1'b0; start = 1'b0;
        if (tr) begin
          chk(done == 1'b0, "R9 no done on trap", int'(done), 0);
          chk(int'(resume_idx) == k, "R9 resume_idx", int'(resume_idx), k);
          chk(!src_en && !dst_en, "R9 loop stopped", int'(src_en | dst_en), 0);
          break;
        end
        if (stp || lst) begin
          chk(done == 1'b1, stp ? "R7 scalar stop done" : "R8 done", int'(done), 1);
          chk(resume_idx == 0, "R8 resume cleared", int'(resume_idx), 0);
          chk(!src_en && !dst_en, "R8 no strobe after end", int'(src_en | dst_en), 0);
          @(posedge clk); @(negedge clk);
          chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
          break;
        end
        k++;
      end
    end
    chk(issued == int'(v.cnt), "R6 issued element count", issued, int'(v.cnt));
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; trap_in = 1'b0;
    vl_in = '0; vstart_in = '0; twin_mode = 1'b0; pred_code = '0;
    pred_x9 = '0; pred_x10 = '0; pred_x11 = '0;
    src_base = '0; dst_base = '0; src_vec = 1'b0; dst_vec = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(done == 0 && src_en == 0 && dst_en == 0, "R1 outputs in reset",
        int'(done | src_en | dst_en), 0);
    chk(resume_idx == 0, "R1 resume in reset", int'(resume_idx), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && src_en == 0 && dst_en == 0, "R1 outputs after reset",
        int'(done | src_en | dst_en), 0);

    for (int i = 0; i < NVEC; i++) begin
      run_case(TBL[i], 1'b0, 1'b0);
      @(negedge clk);
    end

    // R11: start during a run is ignored
    run_case(mk(0, 0, 5, 0, 3, 10, 1, 1, 0, 0, 0, 255, 5), 1'b0, 1'b1);
    @(negedge clk);
    // R12: trap on non-issued cycles has no effect
    run_case(mk(0, 3, 3, 0, 4, 5, 1, 1, 0, 0, 0, 255, 0), 1'b1, 1'b0);
    @(negedge clk);
    // R12 with mix: trap only on skipped elements of a partly enabled run
    run_case(mk(0, 3, 4, 0, 4, 5, 1, 1, 'h0005, 0, 0, 255, 2), 1'b1, 1'b0);
    @(negedge clk);
    // R1: reset clears a resume index left by a trap
    run_case(mk(0, 0, 8, 2, 1, 1, 1, 1, 0, 0, 0, 5, 4), 1'b0, 1'b0);
    chk(resume_idx == 7'd5, "R9 resume held while idle", int'(resume_idx), 5);
    rst_n = 1'b0;
    @(negedge clk);
    chk(resume_idx == 0, "R1 reset clears resume", int'(resume_idx), 0);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule